// File: doc/BRIEF.md
# SDR SDRAM Start-up and Refresh Command Sequencer

This block owns the command pins of one single-rank SDR SDRAM device from the moment reset is released. It raises the clock-enable pin and holds NOP for a programmable settling time. It then closes every bank, runs a burst of auto-refresh cycles and writes the device's mode register. Each command is separated from the next by a parameterised number of SDRAM clocks. When the mode register write has settled, the block raises `init_done` and starts a free-running refresh interval timer.

After start-up the block acts as a refresh agent beside an access engine. Each time the interval timer expires, one refresh is added to a saturating backlog and `refresh_req` is raised. An arbiter grants a bus slot by driving `refresh_ack`. While the block is idle it turns each granted slot into one AUTO REFRESH command and keeps the device's refresh cycle time before it issues the next one. The device geometry and the access timings that the block does not use itself (bank count, row, column and data widths, activate-to-read, activate-to-precharge, write recovery, self-refresh exit) are published in the package for a neighbouring access engine.

Top module: `sdr_cmd_sequencer`

## Requirements
- R1: While reset is high, `sd_cke` is 0, the command `{cs_n,ras_n,cas_n,we_n}` is NOP (4'b0111), `sd_ba` is 0, `init_done` is 0 and `refresh_req` is 0.
- R2: From the first clock after reset release `sd_cke` is 1 and never falls. The first non-NOP command appears on the pins after the PWR_CYCLES-th rising edge with reset low.
- R3: The first command is PRECHARGE ALL, coded 4'b0010, with `sd_addr[10]`=1 and all other address bits 0. The next command follows exactly T_RP clocks later.
- R4: INIT_REFRESHES (8) AUTO REFRESH commands, coded 4'b0001, follow the precharge. Each is exactly T_RC clocks after the previous one.
- R5: LOAD MODE, coded 4'b0000, follows the last start-up refresh by exactly T_RC clocks. It drives `sd_ba`=0 and `sd_addr`=13'h0230: burst length 1 in bits 2:0 (000), sequential order in bit 3 (0), CAS latency 3 in bits 6:4 (011), standard operation in bits 8:7 (00) and single-location writes in bit 9 (1).
- R6: `init_done` rises exactly T_MRD clocks after LOAD MODE and then stays high.
- R7: Every cycle that carries none of the commands listed in R3 to R5 or R9 drives NOP (4'b0111).
- R8: `refresh_req` first rises REFRESH_RELOAD clocks after `init_done` rises. The timer then adds one pending refresh every REFRESH_RELOAD clocks.
- R9: `refresh_req` stays high while any refresh is pending. The block issues no refresh while `refresh_ack` is low. When idle with a pending refresh and `refresh_ack` high, it issues AUTO REFRESH one clock after the ack is sampled, and a grant with nothing pending has no effect.
- R10: Refreshes issued back to back under a held grant are spaced exactly T_RC clocks apart.
- R11: The pending count saturates at PEND_MAX (8). Further expiries while it is full are dropped, so a held grant drains exactly 8 refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM command clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_ack | input | 1 | Grant from the arbiter; a refresh may be issued |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row/mode address bus |
| init_done | output | 1 | Start-up sequence complete |
| refresh_req | output | 1 | At least one refresh is pending |

## Verification
The start-up walk is compared command by command against a table of expected cycles, codes and address words. This table separates a wrong gap after precharge, after refresh or after the mode write from a wrong opcode or a wrong mode word. The refresh side is first left ungranted across ten timer periods, which shows whether a refresh leaks out without a grant and whether the backlog saturates. A held grant then drains the backlog, which exposes wrong spacing and an off-by-one in the backlog count. A final expiry under a grant that is still held checks the one-clock response from idle and the unchanged timer period.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    // Device geometry and access timing, published for the access engine.
    localparam int SD_BANKS  = 4;
    localparam int SD_BA_W   = $clog2(SD_BANKS);
    localparam int SD_ROW_W  = 13;
    localparam int SD_COL_W  = 9;
    localparam int SD_DQ_W   = 16;
    localparam int SD_T_RCD  = 2;
    localparam int SD_T_RAS  = 5;
    localparam int SD_T_WR   = 2;
    localparam int SD_T_XSR  = 7;

    // Address bit that selects all banks during precharge.
    localparam int SD_ALLBANK_BIT = 10;

    // Command code as {cs_n, ras_n, cas_n, we_n}.
    typedef enum logic [3:0] {
        CMD_LOADMODE = 4'b0000,
        CMD_REFRESH  = 4'b0001,
        CMD_PRECHG   = 4'b0010,
        CMD_NOP      = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_POWER,
        PH_PRECH,
        PH_INIT_AREF,
        PH_LOAD,
        PH_IDLE,
        PH_AREF,
        PH_GAP
    } sd_phase_e;

    typedef struct packed {
        logic                cke;
        sd_cmd_e             cmd;
        logic [SD_BA_W-1:0]  ba;
        logic [SD_ROW_W-1:0] addr;
    } sd_pins_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Mode word: write mode [9], op mode [8:7], CAS latency [6:4], order [3], burst [2:0].
    function automatic logic [SD_ROW_W-1:0] mode_word(
        input logic [2:0] burst_code,
        input logic       interleaved,
        input logic [2:0] cas_lat,
        input logic       single_write
    );
        return {3'b000, single_write, 2'b00, cas_lat, interleaved, burst_code};
    endfunction

    localparam logic [SD_ROW_W-1:0] SD_MODE_VALUE = mode_word(3'b000, 1'b0, 3'b011, 1'b1);

endpackage

// File: rtl/sdseq_ticker.sv
module sdseq_ticker #(
    parameter int RELOAD = 761
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    import sdseq_pkg::*;

    localparam int TW = max2(1, $clog2(RELOAD));
    localparam logic [TW-1:0] TOP = TW'(RELOAD - 1);

    logic [TW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= TOP;
        end else if (count_q == '0) begin
            count_q <= TOP;
        end else begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expire = run && (count_q == '0);

endmodule

// File: rtl/sdseq_backlog.sv
module sdseq_backlog #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic add,
    input  logic take,
    output logic pending
);
    import sdseq_pkg::*;

    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

    logic [PW-1:0] depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else begin
            unique case ({add, take})
                2'b10:   if (depth_q != FULL) depth_q <= depth_q + 1'b1;
                2'b01:   if (depth_q != '0)   depth_q <= depth_q - 1'b1;
                default: depth_q <= depth_q;
            endcase
        end
    end

    assign pending = (depth_q != '0);

endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm #(
    parameter int PWR_CYCLES     = 1000000,
    parameter int T_RP           = 2,
    parameter int T_RC           = 6,
    parameter int T_MRD          = 2,
    parameter int INIT_REFRESHES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                grant,
    input  logic                pending,
    output logic                taken,
    output logic                ready,
    output sdseq_pkg::sd_pins_t pins
);
    import sdseq_pkg::*;

    // All gaps are at least two clocks, so a gap state always exists.
    localparam int CW = $clog2(max2(PWR_CYCLES, max2(T_RC, max2(T_RP, T_MRD))) + 1);
    localparam int RW = $clog2(INIT_REFRESHES + 1);
    localparam logic [CW-1:0] PWR_LOAD = CW'(PWR_CYCLES - 1);
    localparam logic [CW-1:0] RP_LOAD  = CW'(T_RP - 2);
    localparam logic [CW-1:0] RC_LOAD  = CW'(T_RC - 2);
    localparam logic [CW-1:0] MRD_LOAD = CW'(T_MRD - 2);

    sd_phase_e     phase_q, ret_q;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] left_q;
    logic          cke_q;
    logic          ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_POWER;
            ret_q   <= PH_PRECH;
            cnt_q   <= PWR_LOAD;
            left_q  <= RW'(INIT_REFRESHES);
            cke_q   <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            cke_q <= 1'b1;
            unique case (phase_q)
                PH_POWER: begin
                    if (cnt_q == '0) phase_q <= PH_PRECH;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                PH_PRECH: begin
                    phase_q <= PH_GAP;
                    cnt_q   <= RP_LOAD;
                    ret_q   <= PH_INIT_AREF;
                end
                PH_INIT_AREF: begin
                    left_q  <= left_q - 1'b1;
                    phase_q <= PH_GAP;
                    cnt_q   <= RC_LOAD;
                    ret_q   <= (left_q == RW'(1)) ? PH_LOAD : PH_INIT_AREF;
                end
                PH_LOAD: begin
                    phase_q <= PH_GAP;
                    cnt_q   <= MRD_LOAD;
                    ret_q   <= PH_IDLE;
                end
                PH_IDLE: begin
                    if (grant && pending) phase_q <= PH_AREF;
                end
                PH_AREF: begin
                    phase_q <= PH_GAP;
                    cnt_q   <= RC_LOAD;
                    ret_q   <= PH_IDLE;
                end
                PH_GAP: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (ret_q == PH_IDLE) begin
                        ready_q <= 1'b1;
                        phase_q <= (grant && pending) ? PH_AREF : PH_IDLE;
                    end else begin
                        phase_q <= ret_q;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        pins.cke  = cke_q;
        pins.ba   = '0;
        pins.addr = '0;
        pins.cmd  = CMD_NOP;
        unique case (phase_q)
            PH_PRECH: begin
                pins.cmd                  = CMD_PRECHG;
                pins.addr[SD_ALLBANK_BIT] = 1'b1;
            end
            PH_INIT_AREF, PH_AREF: pins.cmd = CMD_REFRESH;
            PH_LOAD: begin
                pins.cmd  = CMD_LOADMODE;
                pins.addr = SD_MODE_VALUE;
            end
            default: pins.cmd = CMD_NOP;
        endcase
    end

    assign taken = (phase_q == PH_AREF);
    assign ready = ready_q;

endmodule

// File: rtl/sdr_cmd_sequencer.sv
module sdr_cmd_sequencer #(
    parameter int PWR_CYCLES     = 1000000,
    parameter int T_RP           = 2,
    parameter int T_RC           = 6,
    parameter int T_MRD          = 2,
    parameter int INIT_REFRESHES = 8,
    parameter int REFRESH_RELOAD = 761,
    parameter int PEND_MAX       = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        refresh_ack,
    output logic        sd_cke,
    output logic        sd_cs_n,
    output logic        sd_ras_n,
    output logic        sd_cas_n,
    output logic        sd_we_n,
    output logic [1:0]  sd_ba,
    output logic [12:0] sd_addr,
    output logic        init_done,
    output logic        refresh_req
);
    import sdseq_pkg::*;

    sd_pins_t pins;
    logic     expire, pending, taken, ready;

    sdseq_fsm #(
        .PWR_CYCLES     (PWR_CYCLES),
        .T_RP           (T_RP),
        .T_RC           (T_RC),
        .T_MRD          (T_MRD),
        .INIT_REFRESHES (INIT_REFRESHES)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .grant   (refresh_ack),
        .pending (pending),
        .taken   (taken),
        .ready   (ready),
        .pins    (pins)
    );

    sdseq_ticker #(
        .RELOAD (REFRESH_RELOAD)
    ) u_ticker (
        .clk    (clk),
        .rst    (rst),
        .run    (ready),
        .expire (expire)
    );

    sdseq_backlog #(
        .PEND_MAX (PEND_MAX)
    ) u_backlog (
        .clk     (clk),
        .rst     (rst),
        .add     (expire),
        .take    (taken),
        .pending (pending)
    );

    assign sd_cke                               = pins.cke;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins.cmd;
    assign sd_ba                                = pins.ba;
    assign sd_addr                              = pins.addr;
    assign init_done                            = ready;
    assign refresh_req                          = pending;

endmodule

// File: rtl/sdr_cmd_sequencer_chk.sv
module sdr_cmd_sequencer_chk #(
    parameter int T_RP = 2,
    parameter int T_RC = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        refresh_ack,
    input logic        sd_cke,
    input logic        sd_cs_n,
    input logic        sd_ras_n,
    input logic        sd_cas_n,
    input logic        sd_we_n,
    input logic [1:0]  sd_ba,
    input logic [12:0] sd_addr,
    input logic        init_done,
    input logic        refresh_req
);
    logic [3:0] code;
    logic [3:0] last_q;
    logic [7:0] quiet_q;

    assign code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // NOP cycles since the last real command, saturating.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= 4'b0111;
            quiet_q <= '0;
        end else if (code != 4'b0111) begin
            last_q  <= code;
            quiet_q <= '0;
        end else if (quiet_q != 8'hFF) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
        code == 4'b0111 || code == 4'b0010 || code == 4'b0001 || code == 4'b0000);

    a_r2_cke_holds: assert property (@(posedge clk) disable iff (rst)
        sd_cke |=> sd_cke);

    a_r3_all_banks: assert property (@(posedge clk) disable iff (rst)
        code == 4'b0010 |-> sd_addr == 13'h0400);

    a_r5_mode_word: assert property (@(posedge clk) disable iff (rst)
        code == 4'b0000 |-> (sd_addr == 13'h0230 && sd_ba == 2'b00));

    a_r6_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r8_req_after_init: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> init_done);

    a_r9_granted_only: assert property (@(posedge clk) disable iff (rst)
        (init_done && code == 4'b0001) |-> ($past(refresh_ack) && $past(refresh_req)));

    a_r10_refresh_gap: assert property (@(posedge clk) disable iff (rst)
        (code != 4'b0111 && last_q == 4'b0001) |-> quiet_q >= 8'(T_RC - 1));

    a_r3_precharge_gap: assert property (@(posedge clk) disable iff (rst)
        (code != 4'b0111 && last_q == 4'b0010) |-> quiet_q >= 8'(T_RP - 1));

endmodule

bind sdr_cmd_sequencer sdr_cmd_sequencer_chk #(
    .T_RP (T_RP),
    .T_RC (T_RC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .refresh_ack (refresh_ack),
    .sd_cke      (sd_cke),
    .sd_cs_n     (sd_cs_n),
    .sd_ras_n    (sd_ras_n),
    .sd_cas_n    (sd_cas_n),
    .sd_we_n     (sd_we_n),
    .sd_ba       (sd_ba),
    .sd_addr     (sd_addr),
    .init_done   (init_done),
    .refresh_req (refresh_req)
);

// File: tb/sim_sdr_cmd_sequencer.sv
module sim_sdr_cmd_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int PWR   = 20;
    localparam int RLD   = 100;
    localparam int TRC   = 6;
    localparam int WDOG  = 5000;
    localparam int NINIT = 11;

    // Expected start-up commands: cycle, code, address.
    localparam int EXP_CYC  [NINIT] = '{PWR, PWR+2, PWR+8, PWR+14, PWR+20, PWR+26,
                                        PWR+32, PWR+38, PWR+44, PWR+50, 0};
    localparam int EXP_CODE [NINIT] = '{2, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0};
    localparam int EXP_ADDR [NINIT] = '{32'h400, 0, 0, 0, 0, 0, 0, 0, 0, 32'h230, 0};
    localparam int NTAB = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        refresh_ack = 1'b0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic        init_done, refresh_req;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int nev = 0;
    int ev_cyc [64];
    int ev_code[64];
    int ev_addr[64];
    int ev_ba  [64];
    int first_done = -1;
    int first_req  = -1;
    int cke_bad = 0;
    int done_drop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_cmd_sequencer #(
        .PWR_CYCLES     (PWR),
        .REFRESH_RELOAD (RLD)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .refresh_ack (refresh_ack),
        .sd_cke      (sd_cke),
        .sd_cs_n     (sd_cs_n),
        .sd_ras_n    (sd_ras_n),
        .sd_cas_n    (sd_cas_n),
        .sd_we_n     (sd_we_n),
        .sd_ba       (sd_ba),
        .sd_addr     (sd_addr),
        .init_done   (init_done),
        .refresh_req (refresh_req)
    );

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    // Command log, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111 && nev < 64) begin
                ev_cyc[nev]  = cyc;
                ev_code[nev] = int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
                ev_addr[nev] = int'(sd_addr);
                ev_ba[nev]   = int'(sd_ba);
                nev = nev + 1;
            end
            if (cyc >= 1 && !sd_cke) cke_bad = cke_bad + 1;
            if (init_done && first_done < 0) first_done = cyc;
            if (!init_done && first_done >= 0) done_drop = done_drop + 1;
            if (refresh_req && first_req < 0) first_req = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_cmp = n_cmp + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 1200);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        #2;
        chk("R1 cke", int'(sd_cke), 0);
        chk("R1 cmd", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        chk("R1 ba", int'(sd_ba), 0);
        chk("R1 init_done", int'(init_done), 0);
        chk("R1 refresh_req", int'(refresh_req), 0);
        @(posedge clk);
        #1 rst = 1'b0;

        // R2/R7: NOP before the first command, cke already high
        wait_cyc(PWR - 1);
        chk("R7 nop before precharge", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        chk("R2 cke high", int'(sd_cke), 1);

        // Ten timer periods with no grant: R9 nothing issued, R11 backlog fills
        wait_cyc(1079);
        chk("R9 no refresh without ack", nev, NINIT - 1);
        chk("R9 request held", int'(refresh_req), 1);
        wait_cyc(1080);
        refresh_ack = 1'b1;

        wait_cyc(1150);
        chk("R11 drained count", nev - (NINIT - 1), 8);
        chk("R9 request cleared", int'(refresh_req), 0);

        // Start-up table walk (R2..R5)
        for (int i = 0; i < NTAB; i++) begin
            chk(i == 0 ? "R2/R3 cycle" : (i < 9 ? "R4 cycle" : "R5 cycle"), ev_cyc[i], EXP_CYC[i]);
            chk(i == 0 ? "R3 code" : (i < 9 ? "R4 code" : "R5 code"), ev_code[i], EXP_CODE[i]);
            chk(i == 0 ? "R3 addr" : (i < 9 ? "R4 addr" : "R5 addr"), ev_addr[i], EXP_ADDR[i]);
            chk("R5 ba", ev_ba[i], 0);
        end

        // R9: first grant answered one clock later; R10: spacing
        chk("R9 first grant", ev_cyc[NTAB], 1081);
        for (int i = NTAB; i < NTAB + 8; i++) begin
            chk("R10 spacing", ev_cyc[i], 1081 + TRC * (i - NTAB));
            chk("R10 code", ev_code[i], 1);
        end

        // R6 and R8 timing
        chk("R6 ready cycle", first_done, PWR + 52);
        chk("R6 ready sticky", done_drop, 0);
        chk("R8 first request", first_req, PWR + 52 + RLD);
        chk("R2 cke never low", cke_bad, 0);

        // R8: next expiry under a held grant
        wait_cyc(1180);
        chk("R8 later expiry refresh", nev, NTAB + 9);
        chk("R8 later expiry cycle", ev_cyc[NTAB + 8], PWR + 52 + 11 * RLD + 1);
        chk("R9 request after grant", int'(refresh_req), 0);

        finish_run();
    end

endmodule